// File: doc/BRIEF.md
# Shared Lock Bit Bank

This block keeps a set of single-bit locks that several processors share over one register bus. Each processor has its own request port carrying a valid flag, a lock index and a two-bit operation code. Every cycle a round-robin arbiter accepts at most one request. The accepted operation reads the addressed lock and, in the same clock edge, sets it, clears it or leaves it unchanged. One cycle later the block returns the previous bit and the id of the processor that made the request.

Processors whose instruction set has no atomic read-modify-write use the bank to build spinlocks. A processor that loses arbitration sees its stall line high and keeps its request on the port until the stall drops. Exactly one of several processors racing for a free lock sees success. The number of processors (2 to 8), the number of locks (default 16) and the response data width are parameters.

Top module: `sem_bank_top`

## Requirements
- R1: After a synchronous active-low reset, every lock reads 0, `rsp_valid` is 0 and no stall is raised.
- R2: Op code 2'b01 (test-and-set) returns 1 in bit 0 if the lock was set and 0 if it was clear, and leaves the lock set.
- R3: Op code 2'b10 (test-and-clear) returns the prior value in bit 0 and leaves the lock clear.
- R4: Op code 2'b11 (try-acquire) returns 1 in bit 0 only if the lock was clear before the access, and then sets it. If the lock was already set, it returns 0 and the lock is unchanged.
- R5: Op code 2'b00 (peek) returns the current value in bit 0 and never modifies any lock.
- R6: Every response bit above bit 0 is 0.
- R7: At most one request is accepted per cycle, and one is always accepted when any request is valid. `req_stall[c]` is high in the same cycle exactly when CPU c is requesting and is not accepted.
- R8: The accepted CPU is the first requester found by scanning upward, with wrap-around, from the CPU after the previous winner. The scan starts from CPU 0 after reset.
- R9: `rsp_valid` is high in the cycle after a request is accepted and low otherwise. `rsp_cpu` carries the accepted CPU's id.
- R10: When several CPUs try-acquire the same free lock at once and hold their requests while stalled, exactly one of them receives success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NCPU | Per-CPU request valid |
| req_lock | input | NCPU*LOCK_W | Per-CPU lock index, CPU c in slice [c*LOCK_W +: LOCK_W] |
| req_op | input | NCPU*2 | Per-CPU op code, CPU c in slice [c*2 +: 2] |
| req_stall | output | NCPU | Request present but not accepted this cycle |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_cpu | output | CPU_W | Id of the CPU the response belongs to |
| rsp_data | output | DATA_W | Result in bit 0, other bits zero |

## Verification
On every cycle, the assertions check that the grant is one-hot and stays within the requesters, that no valid request goes unserved, and that `rsp_valid` follows acceptance. They also check how each op code changes the addressed lock and that a peek or a failed try leaves all locks untouched. Only the bench's scenarios can show the round-robin winner order and the returned old values across sequences of operations. Two further behaviours likewise need the scenarios: a contended try-acquire gives exactly one success, and a release lets the next contender in.

// File: rtl/sem_pkg.sv
// Shared definitions for the lock bit bank.
// Assumes two-bit op codes on every request port.
package sem_pkg;

    typedef enum logic [1:0] {
        SEM_PEEK = 2'b00,   // read only
        SEM_TAS  = 2'b01,   // test-and-set
        SEM_TAC  = 2'b10,   // test-and-clear
        SEM_TRY  = 2'b11    // try-acquire, returns success
    } sem_op_e;

    localparam int SEM_OP_W = 2;

endpackage

// File: rtl/sem_rr_arb.sv
// Round-robin arbiter: grants one requester per cycle, scanning upward
// from the CPU after the last winner. Assumes N >= 2.
module sem_rr_arb #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_id
);

    logic [IW-1:0] ptr;

    // Pick the first requester at or after ptr, wrapping around.
    always_comb begin
        int cand;
        logic found;
        gnt    = '0;
        gnt_id = '0;
        found  = 1'b0;
        for (int k = 0; k < N; k++) begin
            cand = int'(ptr) + k;
            if (cand >= N) cand = cand - N;
            if (!found && req[cand]) begin
                found     = 1'b1;
                gnt[cand] = 1'b1;
                gnt_id    = IW'(cand);
            end
        end
    end

    // Move the scan start past the winner on every grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (|req) begin
            if (int'(gnt_id) == N - 1) ptr <= '0;
            else                       ptr <= gnt_id + IW'(1);
        end
    end

    assert_onehot_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    assert_grant_in_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    assert_no_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|gnt));
    assert_ptr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) < N);

endmodule

// File: rtl/sem_req_mux.sv
// Request selector: forwards the lock index and op code of the granted CPU.
// Assumes the grant vector is one-hot or zero.
module sem_req_mux #(
    parameter int NCPU   = 4,
    parameter int LOCK_W = 4
) (
    input  logic [NCPU-1:0]                  gnt,
    input  logic [NCPU*LOCK_W-1:0]           lock_in,
    input  logic [NCPU*sem_pkg::SEM_OP_W-1:0] op_in,
    output logic [LOCK_W-1:0]                lock_sel,
    output sem_pkg::sem_op_e                 op_sel
);

    localparam int OW = sem_pkg::SEM_OP_W;

    // OR together the fields of granted ports.
    always_comb begin
        logic [OW-1:0] op_acc;
        lock_sel = '0;
        op_acc   = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (gnt[c]) begin
                lock_sel = lock_sel | lock_in[c*LOCK_W +: LOCK_W];
                op_acc   = op_acc   | op_in[c*OW +: OW];
            end
        end
        op_sel = sem_pkg::sem_op_e'(op_acc);
    end

endmodule

// File: rtl/sem_lock_bank.sv
// Lock storage: one bit per lock. Returns the addressed bit combinationally
// and applies the op on the clock edge. Out-of-range indices read 0 and write nothing.
module sem_lock_bank #(
    parameter int NLOCK  = 16,
    parameter int LOCK_W = (NLOCK > 1) ? $clog2(NLOCK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LOCK_W-1:0] idx,
    input  sem_pkg::sem_op_e  op,
    output logic              old_bit
);
    import sem_pkg::*;

    logic [NLOCK-1:0] lk;
    logic             in_range;

    // Read the addressed lock before any update.
    always_comb begin
        in_range = (int'(idx) < NLOCK);
        old_bit  = in_range ? lk[idx] : 1'b0;
    end

    // Apply the accepted op to the addressed lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk <= '0;
        end else if (wr_en && in_range) begin
            case (op)
                SEM_TAS, SEM_TRY: lk[idx] <= 1'b1;
                SEM_TAC:          lk[idx] <= 1'b0;
                default:          ;
            endcase
        end
    end

    assert_tas_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_range && op == SEM_TAS) |=> lk[$past(idx)]);
    assert_tac_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_range && op == SEM_TAC) |=> !lk[$past(idx)]);
    assert_try_free_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_range && op == SEM_TRY && !old_bit) |=> lk[$past(idx)]);
    assert_try_held_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == SEM_TRY && old_bit) |=> $stable(lk));
    assert_peek_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == SEM_PEEK) |=> $stable(lk));
    assert_idle_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(lk));

endmodule

// File: rtl/sem_bank_top.sv
// Shared lock bit bank: per-CPU request ports, round-robin acceptance of one
// request per cycle, registered response one cycle later.
// Assumes requesters hold their request while req_stall is high.
module sem_bank_top #(
    parameter int NCPU   = 4,
    parameter int NLOCK  = 16,
    parameter int DATA_W = 32,
    localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int LOCK_W = (NLOCK > 1) ? $clog2(NLOCK) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NCPU-1:0]                 req_valid,
    input  logic [NCPU*LOCK_W-1:0]          req_lock,
    input  logic [NCPU*2-1:0]               req_op,
    output logic [NCPU-1:0]                 req_stall,
    output logic                            rsp_valid,
    output logic [CPU_W-1:0]                rsp_cpu,
    output logic [DATA_W-1:0]               rsp_data
);
    import sem_pkg::*;

    logic [NCPU-1:0]   gnt;
    logic [CPU_W-1:0]  gnt_id;
    logic [LOCK_W-1:0] sel_lock;
    sem_op_e           sel_op;
    logic              any_req;
    logic              old_bit;
    logic              result;

    sem_rr_arb #(.N(NCPU), .IW(CPU_W)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req_valid),
        .gnt    (gnt),
        .gnt_id (gnt_id)
    );

    sem_req_mux #(.NCPU(NCPU), .LOCK_W(LOCK_W)) u_mux (
        .gnt      (gnt),
        .lock_in  (req_lock),
        .op_in    (req_op),
        .lock_sel (sel_lock),
        .op_sel   (sel_op)
    );

    sem_lock_bank #(.NLOCK(NLOCK), .LOCK_W(LOCK_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (any_req),
        .idx     (sel_lock),
        .op      (sel_op),
        .old_bit (old_bit)
    );

    // Stall every requester that was not granted; form the returned bit.
    always_comb begin
        any_req   = |req_valid;
        req_stall = req_valid & ~gnt;
        result    = (sel_op == SEM_TRY) ? ~old_bit : old_bit;
    end

    // Register the response of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_cpu   <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= any_req;
            if (any_req) begin
                rsp_cpu  <= gnt_id;
                rsp_data <= {{(DATA_W-1){1'b0}}, result};
            end
        end
    end

    assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid == $past(any_req)));
    assert_stall_only_requesters_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stall & ~req_valid) == '0);
    assert_one_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> ($countones(req_valid & ~req_stall) == 1));
    assert_try_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && sel_op == SEM_TRY) |=> (rsp_data[0] == !$past(old_bit)));

endmodule

// File: tb/sem_bank_top_tb.sv
module sem_bank_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N    = 4;
    localparam int NL   = 16;
    localparam int DW   = 32;
    localparam int LW   = 4;
    localparam int CW   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      req_valid = '0;
    logic [N*LW-1:0]   req_lock = '0;
    logic [N*2-1:0]    req_op = '0;
    logic [N-1:0]      req_stall;
    logic              rsp_valid;
    logic [CW-1:0]     rsp_cpu;
    logic [DW-1:0]     rsp_data;

    sem_bank_top #(.NCPU(N), .NLOCK(NL), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lock(req_lock),
        .req_op(req_op), .req_stall(req_stall), .rsp_valid(rsp_valid),
        .rsp_cpu(rsp_cpu), .rsp_data(rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Drive values and reference model state
    bit      drv_v [N];
    int      drv_l [N];
    int      drv_o [N];
    bit      m_lock [NL];
    int      m_ptr = 0;
    int      m_win;
    bit      exp_vld = 0;
    int      exp_cpu = 0;
    logic [DW-1:0] exp_data = '0;
    logic [DW-1:0] last_data;
    bit      counting = 0;
    int      succ = 0;

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic clear_drv();
        for (int c = 0; c < N; c++) begin drv_v[c] = 0; drv_l[c] = 0; drv_o[c] = 0; end
    endtask

    // One clock: check last response, drive new requests, predict result.
    task automatic cycle(string tag);
        logic [N-1:0] exp_stall;
        int cand;
        bit old, res;
        @(negedge clk);
        check(rsp_valid === exp_vld, "R9 valid", rsp_valid, exp_vld);
        if (exp_vld) begin
            check(rsp_cpu === CW'(exp_cpu), "R8 winner", rsp_cpu, exp_cpu);
            check(rsp_data === exp_data, tag, rsp_data, exp_data);
            check(rsp_data[DW-1:1] === '0, "R6", rsp_data, exp_data);
            last_data = rsp_data;
            if (counting && rsp_data[0]) succ++;
        end
        for (int c = 0; c < N; c++) begin
            req_valid[c]         = drv_v[c];
            req_lock[c*LW +: LW] = LW'(drv_l[c]);
            req_op[c*2 +: 2]     = 2'(drv_o[c]);
        end
        #1;
        m_win = -1;
        if (rst_n) begin
            for (int k = 0; k < N; k++) begin
                cand = (m_ptr + k) % N;
                if (m_win < 0 && drv_v[cand]) m_win = cand;
            end
        end
        exp_stall = '0;
        for (int c = 0; c < N; c++) if (drv_v[c] && c != m_win && rst_n) exp_stall[c] = 1'b1;
        if (rst_n) check(req_stall === exp_stall, "R7 stall", req_stall, exp_stall);
        if (m_win >= 0) begin
            old = m_lock[drv_l[m_win]];
            case (drv_o[m_win])
                1: begin res = old;  m_lock[drv_l[m_win]] = 1; end
                2: begin res = old;  m_lock[drv_l[m_win]] = 0; end
                3: begin res = !old; m_lock[drv_l[m_win]] = 1; end
                default: res = old;
            endcase
            exp_vld  = 1;
            exp_cpu  = m_win;
            exp_data = {{(DW-1){1'b0}}, res};
            m_ptr    = (m_win + 1) % N;
        end else begin
            exp_vld = 0;
        end
    endtask

    task automatic single(int cpu, int lk, int op, bit expb, string tag);
        clear_drv();
        drv_v[cpu] = 1; drv_l[cpu] = lk; drv_o[cpu] = op;
        cycle(tag);
        clear_drv();
        cycle(tag);
        check(last_data === {{(DW-1){1'b0}}, expb}, tag, last_data, expb);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        clear_drv();
        for (int i = 0; i < NL; i++) m_lock[i] = 0;
        repeat (3) cycle("R1");
        rst_n = 1'b1;
        cycle("R1");
        check(rsp_valid === 1'b0, "R1 rsp_valid", rsp_valid, 0);
        check(req_stall === '0, "R1 stall", req_stall, 0);
        for (int i = 0; i < NL; i++) single(i % N, i, 0, 0, "R1 lock clear");

        // R2 test-and-set
        single(1, 3, 1, 0, "R2 set from clear");
        single(2, 3, 1, 1, "R2 set when held");
        // R5 peek twice without change
        single(0, 3, 0, 1, "R5 peek held");
        single(3, 3, 0, 1, "R5 peek unchanged");
        single(3, 4, 0, 0, "R5 peek clear");
        // R3 test-and-clear
        single(2, 3, 2, 1, "R3 clear held");
        single(2, 3, 2, 0, "R3 clear free");
        single(0, 3, 0, 0, "R3 stays clear");
        // R4 try-acquire
        single(0, 5, 3, 1, "R4 try free");
        single(3, 5, 3, 0, "R4 try held");
        single(1, 5, 0, 1, "R4 still held");
        single(1, 5, 2, 1, "R4 release");

        // R10 contention on lock 7, requests held while stalled
        for (int round = 0; round < 2; round++) begin
            bit pend [N];
            bit any;
            for (int c = 0; c < N; c++) pend[c] = 1;
            succ = 0;
            counting = 1;
            any = 1;
            while (any) begin
                clear_drv();
                for (int c = 0; c < N; c++) if (pend[c]) begin drv_v[c] = 1; drv_l[c] = 7; drv_o[c] = 3; end
                cycle("R10 contend");
                if (m_win >= 0) pend[m_win] = 0;
                any = 0;
                for (int c = 0; c < N; c++) if (pend[c]) any = 1;
            end
            clear_drv();
            cycle("R10 contend");
            counting = 0;
            check(succ == 1, "R10 one winner", succ, 1);
            single(0, 7, 2, 1, "R10 release");
        end

        // R8 round-robin with all CPUs peeking continuously
        for (int t = 0; t < 9; t++) begin
            for (int c = 0; c < N; c++) begin drv_v[c] = 1; drv_l[c] = c; drv_o[c] = 0; end
            cycle("R8 rr");
        end
        // R8 sparse requesters
        for (int t = 0; t < 6; t++) begin
            clear_drv();
            drv_v[1] = 1; drv_v[3] = 1; drv_l[1] = 9; drv_l[3] = 9; drv_o[1] = 1; drv_o[3] = 2;
            cycle("R8 sparse");
        end

        // Mixed random traffic
        for (int t = 0; t < 600; t++) begin
            for (int c = 0; c < N; c++) begin
                drv_v[c] = ($urandom % 3) != 0;
                drv_l[c] = $urandom % NL;
                drv_o[c] = $urandom % 4;
            end
            cycle("R2/R3/R4/R5 mixed");
        end
        clear_drv();
        cycle("mixed");
        cycle("mixed");
        finish_run();
    end

endmodule